// File: doc/BRIEF.md
# Scan-Chain Register Access Port

This block sits behind a JTAG TAP controller and turns data-register scans into accesses on a parallel register bus. The TAP controller is outside the block. It supplies the current instruction and decoded strobes for the Capture-DR, Shift-DR and Update-DR states, all in the TCK domain. The block owns three data registers. The first is a 5-bit chain-select register, used under the chain-select instruction. The second is a 40-bit access register, used under the access instruction while chain 0 is selected. The third is a 1-bit bypass register for every other case.

An access scan carries three fields. Bits 31..0 are the data field, bits 38..32 are the register address and bit 39 is the direction flag. On Update-DR the block issues one write or one read on the bus. Read data comes back one scan late: the following Capture-DR loads it into the data field. Software therefore ends every read sequence with a dummy scan. That scan should address a register whose read has no side effect, so that a destructive register such as a FIFO data port is not read twice.

Top module: `jtag_reg_access`

## Requirements
- R1: While rst_ni is low and after it rises, bus_we_o and bus_re_o are 0 and the chain-select register holds all ones (no chain), so the access instruction (code 0xC) reaches no bus and acts as a 1-bit bypass.
- R2: Under instruction 0x2, the DR is a 5-bit chain-select register, shifted in LSB first from tdi_i. Capture-DR loads the chain number currently in force, and Update-DR makes the shifted value the new chain number.
- R3: Under instruction 0xC with chain 0 selected, the DR is 40 bits, shifted LSB first: bits 31..0 are data, bits 38..32 are the address, and bit 39 is 1 for write and 0 for read. bus_addr_o changes only after an Update-DR.
- R4: An Update-DR with bit 39 set raises bus_we_o for exactly one TCK cycle, starting one cycle after the update strobe, with bus_addr_o and bus_wdata_o taken from the scanned fields.
- R5: An Update-DR with bit 39 clear raises bus_re_o for exactly one TCK cycle, starting one cycle after the update strobe. bus_rdata_i is sampled at the end of that cycle.
- R6: The next Capture-DR of the access register loads the sampled read data into bits 31..0 and zeros into bits 39..32. These bits are shifted out on tdo_o LSB first.
- R7: A capture that follows a write scan returns the data of the last read again; writes never alter the held read data.
- R8: Under instruction 0xC with a nonzero chain selected, no bus strobe is issued and the DR is the 1-bit bypass register.
- R9: Under any instruction other than 0x2 and 0xC, the DR is a 1-bit bypass that captures 0, so tdo_o shows the previous tdi_i bit.
- R10: Each update of the access register produces exactly one bus strobe. bus_we_o and bus_re_o are never high together, and no strobe appears without a preceding access update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tdi_i | input | 1 | Serial data in |
| ir_i | input | 4 | Current instruction from the TAP |
| capture_dr_i | input | 1 | TAP is in Capture-DR |
| shift_dr_i | input | 1 | TAP is in Shift-DR |
| update_dr_i | input | 1 | TAP is in Update-DR |
| tdo_o | output | 1 | Serial data out, LSB of the selected DR |
| bus_addr_o | output | 7 | Register address |
| bus_wdata_o | output | 32 | Write data |
| bus_we_o | output | 1 | Single-cycle write strobe |
| bus_re_o | output | 1 | Single-cycle read strobe |
| bus_rdata_i | input | 32 | Read data, valid while bus_re_o is high |

## Verification
The bench models the bus with one register per address and a popping FIFO port at address 4. It counts every strobe, so that a double-issued read shows up as a skipped FIFO entry and a write-plus-read shows up as a surplus count. It sweeps every address with writes and then reads them back with pipelined scans. A design that returned data in the same scan, or that shifted fields in the wrong order, would misalign all of these reads. It also shifts patterns through the bypass path with an unselected chain and with a foreign instruction. A design that gated the access only on the instruction would strobe the bus there, and one that captured 1 into bypass would offset the output stream.

// File: rtl/jtag_reg_access_pkg.sv
package jtag_reg_access_pkg;
  localparam int unsigned IR_W      = 4;
  localparam int unsigned CHAIN_W   = 5;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 7;
  localparam logic [IR_W-1:0] SEL_CODE = 4'h2;
  localparam logic [IR_W-1:0] ACC_CODE = 4'hC;

  typedef enum logic [1:0] {
    SRC_BYP = 2'd0,
    SRC_SEL = 2'd1,
    SRC_ACC = 2'd2
  } tdo_src_e;
endpackage

// File: rtl/jrab_chain_sel.sv
module jrab_chain_sel #(
  parameter int unsigned CHAIN_W = 5
) (
  input  logic               tck_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               capture_i,
  input  logic               shift_i,
  input  logic               update_i,
  input  logic               tdi_i,
  output logic               tdo_o,
  output logic [CHAIN_W-1:0] chain_o
);
  logic [CHAIN_W-1:0] sh_q, chain_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      chain_q <= '1;
    end else if (en_i) begin
      if (capture_i)     sh_q    <= chain_q;
      else if (shift_i)  sh_q    <= {tdi_i, sh_q[CHAIN_W-1:1]};
      else if (update_i) chain_q <= sh_q;
    end
  end

  assign tdo_o   = sh_q[0];
  assign chain_o = chain_q;
endmodule

// File: rtl/jrab_access_reg.sv
module jrab_access_reg #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 7
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              update_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_we_o,
  output logic              bus_re_o,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  localparam int unsigned LEN   = DATA_W + ADDR_W + 1;
  localparam int unsigned A_LSB = DATA_W;
  localparam int unsigned WR_B  = LEN - 1;

  logic [LEN-1:0]    sh_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, hold_q, hold_nx;
  logic              we_q, re_q;

  // read data is taken while the strobe is high; capture may see it the same edge
  assign hold_nx = re_q ? bus_rdata_i : hold_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      hold_q  <= '0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
    end else begin
      we_q   <= 1'b0;
      re_q   <= 1'b0;
      hold_q <= hold_nx;
      if (en_i) begin
        if (capture_i) begin
          sh_q <= {{(ADDR_W+1){1'b0}}, hold_nx};
        end else if (shift_i) begin
          sh_q <= {tdi_i, sh_q[LEN-1:1]};
        end else if (update_i) begin
          addr_q <= sh_q[A_LSB +: ADDR_W];
          if (sh_q[WR_B]) begin
            wdata_q <= sh_q[DATA_W-1:0];
            we_q    <= 1'b1;
          end else begin
            re_q    <= 1'b1;
          end
        end
      end
    end
  end

  assign tdo_o       = sh_q[0];
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
  assign bus_we_o    = we_q;
  assign bus_re_o    = re_q;
endmodule

// File: rtl/jrab_bypass.sv
module jrab_bypass (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic capture_i,
  input  logic shift_i,
  input  logic tdi_i,
  output logic tdo_o
);
  logic byp_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                 byp_q <= 1'b0;
    else if (en_i && capture_i)  byp_q <= 1'b0;
    else if (en_i && shift_i)    byp_q <= tdi_i;
  end

  assign tdo_o = byp_q;
endmodule

// File: rtl/jtag_reg_access.sv
module jtag_reg_access
  import jtag_reg_access_pkg::*;
#(
  parameter int unsigned          P_IR_W    = IR_W,
  parameter int unsigned          P_CHAIN_W = CHAIN_W,
  parameter int unsigned          P_DATA_W  = DATA_W,
  parameter int unsigned          P_ADDR_W  = ADDR_W,
  parameter logic [P_IR_W-1:0]    P_SEL     = SEL_CODE,
  parameter logic [P_IR_W-1:0]    P_ACC     = ACC_CODE,
  parameter logic [P_CHAIN_W-1:0] P_CHAIN   = '0
) (
  input  logic                tck_i,
  input  logic                rst_ni,
  input  logic                tdi_i,
  input  logic [P_IR_W-1:0]   ir_i,
  input  logic                capture_dr_i,
  input  logic                shift_dr_i,
  input  logic                update_dr_i,
  output logic                tdo_o,
  output logic [P_ADDR_W-1:0] bus_addr_o,
  output logic [P_DATA_W-1:0] bus_wdata_o,
  output logic                bus_we_o,
  output logic                bus_re_o,
  input  logic [P_DATA_W-1:0] bus_rdata_i
);
  logic [P_CHAIN_W-1:0] chain;
  logic                 sel_en, acc_en, byp_en;
  logic                 sel_tdo, acc_tdo, byp_tdo;
  tdo_src_e             src;

  assign sel_en = (ir_i == P_SEL);
  assign acc_en = (ir_i == P_ACC) && (chain == P_CHAIN);
  assign byp_en = !sel_en && !acc_en;

  jrab_chain_sel #(.CHAIN_W(P_CHAIN_W)) i_sel (
    .tck_i, .rst_ni, .en_i(sel_en),
    .capture_i(capture_dr_i), .shift_i(shift_dr_i), .update_i(update_dr_i),
    .tdi_i, .tdo_o(sel_tdo), .chain_o(chain)
  );

  jrab_access_reg #(.DATA_W(P_DATA_W), .ADDR_W(P_ADDR_W)) i_acc (
    .tck_i, .rst_ni, .en_i(acc_en),
    .capture_i(capture_dr_i), .shift_i(shift_dr_i), .update_i(update_dr_i),
    .tdi_i, .tdo_o(acc_tdo),
    .bus_addr_o, .bus_wdata_o, .bus_we_o, .bus_re_o, .bus_rdata_i
  );

  jrab_bypass i_byp (
    .tck_i, .rst_ni, .en_i(byp_en),
    .capture_i(capture_dr_i), .shift_i(shift_dr_i),
    .tdi_i, .tdo_o(byp_tdo)
  );

  always_comb begin
    if (acc_en)      src = SRC_ACC;
    else if (sel_en) src = SRC_SEL;
    else             src = SRC_BYP;
  end

  always_comb begin
    unique case (src)
      SRC_ACC: tdo_o = acc_tdo;
      SRC_SEL: tdo_o = sel_tdo;
      default: tdo_o = byp_tdo;
    endcase
  end
endmodule

// File: rtl/jtag_reg_access_chk.sv
module jtag_reg_access_chk #(
  parameter int unsigned       P_IR_W   = 4,
  parameter int unsigned       P_ADDR_W = 7,
  parameter logic [P_IR_W-1:0] P_ACC    = 4'hC
) (
  input logic                tck_i,
  input logic                rst_ni,
  input logic [P_IR_W-1:0]   ir_i,
  input logic                update_dr_i,
  input logic [P_ADDR_W-1:0] bus_addr_o,
  input logic                bus_we_o,
  input logic                bus_re_o
);
  AST_WE_SINGLE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    bus_we_o |=> !bus_we_o) else $error("we held"); // R4
  AST_RE_SINGLE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    bus_re_o |=> !bus_re_o) else $error("re held"); // R5
  AST_NO_BOTH: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !(bus_we_o && bus_re_o)) else $error("we and re"); // R10
  AST_FROM_UPDATE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (bus_we_o || bus_re_o) |-> ($past(update_dr_i) && $past(ir_i) == P_ACC))
    else $error("stray strobe"); // R8
  AST_ADDR_HOLD: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !update_dr_i |=> $stable(bus_addr_o)) else $error("addr moved"); // R3
endmodule

bind jtag_reg_access jtag_reg_access_chk #(
  .P_IR_W(P_IR_W), .P_ADDR_W(P_ADDR_W), .P_ACC(P_ACC)
) i_chk (
  .tck_i(tck_i), .rst_ni(rst_ni), .ir_i(ir_i), .update_dr_i(update_dr_i),
  .bus_addr_o(bus_addr_o), .bus_we_o(bus_we_o), .bus_re_o(bus_re_o)
);

// File: tb/test_jtag_reg_access.sv
`timescale 1ns/1ps
module test_jtag_reg_access;
  localparam logic [31:0] ID = 32'h4A7C_0001;

  logic        tck = 0, rst_n = 0, tdi = 0, cap = 0, shf = 0, upd = 0;
  logic [3:0]  ir = 4'hF;
  logic        tdo, we, re;
  logic [6:0]  addr;
  logic [31:0] wdata, rdata;
  logic [31:0] regs [128];
  int unsigned rptr = 0, we_cnt = 0, re_cnt = 0, cyc = 0;
  int          checks = 0, fails = 0;
  logic        s_we, s_re;
  logic [6:0]  s_addr;
  logic [31:0] s_wdata;

  always #10 tck = ~tck;

  jtag_reg_access i_jtag_reg_access (
    .tck_i(tck), .rst_ni(rst_n), .tdi_i(tdi), .ir_i(ir),
    .capture_dr_i(cap), .shift_dr_i(shf), .update_dr_i(upd), .tdo_o(tdo),
    .bus_addr_o(addr), .bus_wdata_o(wdata), .bus_we_o(we), .bus_re_o(re),
    .bus_rdata_i(rdata)
  );

  function automatic logic [31:0] fifo_val(int unsigned i);
    return 32'hC0DE_0000 + i * 3;
  endfunction

  assign rdata = (addr == 7'd0) ? ID : (addr == 7'd4) ? fifo_val(rptr) : regs[addr];

  always @(posedge tck) begin
    if (we) begin
      we_cnt <= we_cnt + 1;
      if (addr != 7'd0 && addr != 7'd4) regs[addr] <= wdata;
    end
    if (re) begin
      re_cnt <= re_cnt + 1;
      if (addr == 7'd4) rptr <= rptr + 1;
    end
  end

  always @(posedge tck) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic scan(input int n, input logic [39:0] din, output logic [39:0] dout);
    dout = '0;
    @(negedge tck) cap = 1;
    @(negedge tck) cap = 0;
    for (int i = 0; i < n; i++) begin
      shf = 1; tdi = din[i]; dout[i] = tdo;
      @(negedge tck);
    end
    shf = 0; upd = 1;
    @(negedge tck) upd = 0;
    s_we = we; s_re = re; s_addr = addr; s_wdata = wdata;
    @(negedge tck);
    chk("R10 strobe one cycle", {62'd0, we, re}, 64'd0);
  endtask

  initial begin
    logic [39:0] d;
    int unsigned w0, r0;
    logic [31:0] exp_prev;
    for (int i = 0; i < 128; i++) regs[i] = 32'h0;
    repeat (3) @(negedge tck);
    chk("R1 reset strobes", {62'd0, we, re}, 64'd0);
    chk("R1 reset tdo", tdo, 0);
    rst_n = 1;
    @(negedge tck);

    // access instruction with no chain selected: bypass, no strobe
    ir = 4'hC; w0 = we_cnt; r0 = re_cnt;
    scan(40, {1'b1, 7'd9, 32'hA5A5_1234}, d);
    chk("R1 no access after reset", we_cnt + re_cnt, w0 + r0);
    chk("R8 bypass stream", d, {7'd9, 32'hA5A5_1234, 1'b0});

    // chain select: capture shows current chain
    ir = 4'h2;
    scan(5, 40'd3, d);
    chk("R2 capture reset chain", d[4:0], 5'h1F);
    ir = 4'hC; w0 = we_cnt;
    scan(40, {1'b1, 7'd9, 32'h1}, d);
    chk("R8 chain 3 no write", we_cnt, w0);
    chk("R8 chain 3 bypass", d[1:0], 2'b10);
    ir = 4'h2;
    scan(5, 40'd0, d);
    chk("R2 capture chain 3", d[4:0], 5'd3);

    // write then read with dummy terminator
    ir = 4'hC; w0 = we_cnt;
    scan(40, {1'b1, 7'd5, 32'hDEAD_BEEF}, d);
    chk("R4 we pulse", {62'd0, s_we, s_re}, 64'd2);
    chk("R4 addr", s_addr, 7'd5);
    chk("R4 wdata", s_wdata, 32'hDEAD_BEEF);
    chk("R4 one write", we_cnt, w0 + 1);
    chk("R3 register written", regs[5], 32'hDEAD_BEEF);
    r0 = re_cnt;
    scan(40, {1'b0, 7'd5, 32'h0}, d);
    chk("R5 re pulse", {62'd0, s_we, s_re}, 64'd1);
    chk("R5 one read", re_cnt, r0 + 1);
    scan(40, {1'b0, 7'd0, 32'h0}, d);
    chk("R6 read data next scan", d[31:0], 32'hDEAD_BEEF);
    chk("R6 upper bits zero", d[39:32], 8'd0);

    // held data survives writes
    scan(40, {1'b1, 7'd6, 32'h0000_1234}, d);
    chk("R7 id from dummy", d[31:0], ID);
    scan(40, {1'b1, 7'd7, 32'h0000_5678}, d);
    chk("R7 held after write", d[31:0], ID);
    chk("R7 write landed", regs[6], 32'h1234);

    // FIFO port: each read pops exactly once
    r0 = re_cnt;
    for (int k = 0; k < 7; k++) begin
      scan(40, {1'b0, (k < 6) ? 7'd4 : 7'd0, 32'h0}, d);
      if (k > 0) chk("R6 fifo order", d[31:0], fifo_val(k - 1));
    end
    scan(40, {1'b1, 7'd8, 32'h0}, d);
    chk("R10 fifo pops", rptr, 6);
    chk("R10 read count", re_cnt, r0 + 7);
    chk("R6 terminator id", d[31:0], ID);

    // foreign instruction: bypass
    ir = 4'h7; w0 = we_cnt; r0 = re_cnt;
    scan(8, 40'hA5, d);
    chk("R9 bypass", d[7:0], 8'h4A);
    chk("R9 no strobe", we_cnt + re_cnt, w0 + r0);

    // sweep all addresses
    ir = 4'hC;
    for (int a = 1; a < 128; a++)
      if (a != 4) scan(40, {1'b1, 7'(a), 32'(a) * 32'h0101_0101 ^ 32'h5A5A_0000}, d);
    exp_prev = 32'h0;
    for (int a = 1; a < 129; a++) begin
      if (a == 4) continue;
      scan(40, {1'b0, (a < 128) ? 7'(a) : 7'd0, 32'h0}, d);
      if (a > 1) chk("R3 sweep readback", d[31:0], exp_prev);
      exp_prev = 32'(a) * 32'h0101_0101 ^ 32'h5A5A_0000;
    end
    chk("R3 sweep last", d[39:32], 8'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule